// File: doc/BRIEF.md
# Kernel Completion Tracker

This block counts finished workgroups for each in-flight kernel. It tells the host when a kernel has finished all of its workgroups. A launch strobe loads a slot with the kernel's workgroup total and two optional host addresses: a notify flag and a timing record. Each completion event on the input stream names a kernel. When a kernel's count reaches its total, the block does three things. It marks the kernel done. It queues the kernel's ID in a done queue. It then runs a short memory sequence on a request port.

The memory sequence has up to four steps, in this order. First, the value 1 is written to the notify address. Next, the shared outstanding-dispatch counter is read and written back one lower. Last, the end time is written to the timing record, in nanoseconds. The end time is the number of clock cycles since reset, divided by 1000 and rounded down.

A scheduling-pass strobe coalesces the wake-ups. If any kernel finished since the last pass, one wake pulse is raised. The queued IDs are then drained out of the retire stream in completion order. Every accepted completion also arms a pending-tick flag, and the next pass clears it.

The completion input, the memory request port and the retire output are valid/ready streams. A source holds valid, and the payload stays unchanged, until the cycle in which ready is seen high. The block keeps completion ready low for as long as a memory sequence is in flight. It holds a memory request stable while the request port's ready is low. It holds the retire head while retire ready is low. A read response is a single-cycle valid pulse with data, and it has no ready.

Top module: `kernel_done_tracker`

## Requirements
- R1: Each accepted completion adds one to the count of the kernel named by cmp_id. A kernel whose count is below its total has a kernel_done bit of 0.
- R2: The cycle after the accepted completion that makes the count equal to the total, kernel_done[id] becomes 1.
- R3: On finishing, if the kernel's notify address is nonzero, a write of data 1 to that address is issued first. If the address is zero, that step is skipped.
- R4: On finishing, a read (mem_req_write=0) of cnt_addr is issued. The response value minus one is then written to cnt_addr.
- R5: If the kernel's timing-record address is nonzero, the last request is a write to it. Its data is floor(N/1000), where N is the number of clock edges from reset release to the edge that accepted the finishing completion. If the address is zero, that write is skipped.
- R6: The requests are issued in the order notify, read, write-back, timestamp. cmp_ready stays 0 from the finishing edge until the last request is accepted. A request is held stable while mem_req_ready is 0.
- R7: sched_pass with a non-empty done queue gives exactly one wake pulse, one cycle later. sched_pass with an empty queue gives no wake pulse.
- R8: After such a pass, the queued IDs appear on retire_id in the order the kernels finished, one per retire handshake. The head is held while retire_ready is 0. retire_valid returns to 0 once the queue is empty.
- R9: A completion accepted for a kernel that is not done sets tick_pending on the next cycle. sched_pass clears it.
- R10: A completion for a kernel that is already done pulses cmp_err one cycle later and is otherwise ignored: no memory request and no change to kernel_done.
- R11: launch_valid loads the slot named by launch_id with its total and its two addresses, and clears that slot's count and done bit.
- R12: After reset, kernel_done, tick_pending, wake, cmp_err, retire_valid and mem_req_valid are 0, and cmp_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Load a kernel slot |
| launch_id | input | ID_W | Slot to load |
| launch_total | input | WG_W | Workgroup total (at least 1) |
| launch_notify_addr | input | ADDR_W | Notify flag address, 0 = none |
| launch_stamp_addr | input | ADDR_W | Timing record address, 0 = none |
| cnt_addr | input | ADDR_W | Address of the outstanding-dispatch counter |
| cmp_valid | input | 1 | Completion event valid |
| cmp_ready | output | 1 | Completion event accepted when high |
| cmp_id | input | ID_W | Kernel that finished a workgroup |
| cmp_err | output | 1 | Pulse: completion for an already-done kernel |
| kernel_done | output | N_KERN | Per-kernel done flags |
| sched_pass | input | 1 | Scheduling pass strobe |
| tick_pending | output | 1 | A scheduling tick is armed |
| wake | output | 1 | Host wake-up pulse |
| retire_valid | output | 1 | Drained done-queue entry valid |
| retire_ready | input | 1 | Drained entry taken when high |
| retire_id | output | ID_W | Drained kernel ID |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted when high |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_data | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read response pulse |
| mem_rsp_data | input | DATA_W | Read response data |

## Verification
The bench sends completions one short of a kernel's total, to catch a tracker that finishes one workgroup early. It then compares the memory trace against the expected order and data, including the case where the notify and timestamp steps are absent and the case where the request port stalls every other cycle. A design that dropped a skipped step wrongly, or lost the hold under back-pressure, would show a wrong or missing trace entry. The bench also repeats a completion for a finished kernel, which must give an error pulse and no memory traffic. It checks that a pass gives a single wake pulse and drains the IDs in finish order while retire is stalled, and that a pass over an empty queue gives no wake at all. A relaunch must clear the stale done flag.

// File: rtl/kdt_pkg.sv
package kdt_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_NOTE,
    SQ_RDREQ,
    SQ_RDWAIT,
    SQ_WRREQ,
    SQ_STAMP
  } seq_state_e;
endpackage

// File: rtl/kdt_ns_clock.sv
module kdt_ns_clock #(
  parameter int TICKS_PER_NS = 1000,
  parameter int NS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NS_W-1:0] ns_now
);
  localparam int SUB_W = (TICKS_PER_NS > 1) ? $clog2(TICKS_PER_NS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_NS - 1);

  logic [SUB_W-1:0] sub_q;
  logic [NS_W-1:0]  ns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      ns_q  <= '0;
    end else if (sub_q == SUB_LAST) begin
      sub_q <= '0;
      ns_q  <= ns_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign ns_now = ns_q;
endmodule

// File: rtl/kdt_slot.sv
module kdt_slot #(
  parameter int WG_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WG_W-1:0]   load_total,
  input  logic [ADDR_W-1:0] load_notify,
  input  logic [ADDR_W-1:0] load_stamp,
  input  logic              bump,
  output logic              done,
  output logic [WG_W-1:0]   count,
  output logic [WG_W-1:0]   total,
  output logic [ADDR_W-1:0] notify,
  output logic [ADDR_W-1:0] stamp
);
  logic [WG_W-1:0] count_inc;
  assign count_inc = count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      count  <= '0;
      total  <= '0;
      notify <= '0;
      stamp  <= '0;
    end else if (load) begin
      done   <= 1'b0;
      count  <= '0;
      total  <= load_total;
      notify <= load_notify;
      stamp  <= load_stamp;
    end else if (bump) begin
      count <= count_inc;
      if (count_inc == total) done <= 1'b1;
    end
  end
endmodule

// File: rtl/kdt_done_fifo.sv
module kdt_done_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0] CNT_FULL = (PTR_W + 1)'(DEPTH);

  logic [W-1:0]   mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;
  logic do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_data;
        wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/kdt_mem_seq.sv
module kdt_mem_seq
  import kdt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_notify,
  input  logic [ADDR_W-1:0] start_stamp,
  input  logic [DATA_W-1:0] start_ns,
  input  logic [ADDR_W-1:0] cnt_addr,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  seq_state_e st_q;
  logic [ADDR_W-1:0] note_q, stamp_q;
  logic [DATA_W-1:0] ns_q, val_q;
  logic fire;

  assign fire = mem_req_valid && mem_req_ready;
  assign busy = (st_q != SQ_IDLE);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b1;
    mem_req_addr  = '0;
    mem_req_data  = '0;
    unique case (st_q)
      SQ_NOTE: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = note_q;
        mem_req_data  = DATA_W'(1);
      end
      SQ_RDREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b0;
        mem_req_addr  = cnt_addr;
      end
      SQ_WRREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cnt_addr;
        mem_req_data  = val_q;
      end
      SQ_STAMP: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = stamp_q;
        mem_req_data  = ns_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      note_q  <= '0;
      stamp_q <= '0;
      ns_q    <= '0;
      val_q   <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          note_q  <= start_notify;
          stamp_q <= start_stamp;
          ns_q    <= start_ns;
          st_q    <= (start_notify != '0) ? SQ_NOTE : SQ_RDREQ;
        end
        SQ_NOTE:   if (fire) st_q <= SQ_RDREQ;
        SQ_RDREQ:  if (fire) st_q <= SQ_RDWAIT;
        SQ_RDWAIT: if (mem_rsp_valid) begin
          val_q <= mem_rsp_data - 1'b1;
          st_q  <= SQ_WRREQ;
        end
        SQ_WRREQ:  if (fire) st_q <= (stamp_q != '0) ? SQ_STAMP : SQ_IDLE;
        SQ_STAMP:  if (fire) st_q <= SQ_IDLE;
        default:   st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kernel_done_tracker.sv
module kernel_done_tracker #(
  parameter int N_KERN = 4,
  parameter int WG_W = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TICKS_PER_NS = 1000,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           launch_valid,
  input  logic [((N_KERN > 1) ? $clog2(N_KERN) : 1)-1:0] launch_id,
  input  logic [WG_W-1:0]                                launch_total,
  input  logic [ADDR_W-1:0]                              launch_notify_addr,
  input  logic [ADDR_W-1:0]                              launch_stamp_addr,
  input  logic [ADDR_W-1:0]                              cnt_addr,
  input  logic                                           cmp_valid,
  output logic                                           cmp_ready,
  input  logic [((N_KERN > 1) ? $clog2(N_KERN) : 1)-1:0] cmp_id,
  output logic                                           cmp_err,
  output logic [N_KERN-1:0]                              kernel_done,
  input  logic                                           sched_pass,
  output logic                                           tick_pending,
  output logic                                           wake,
  output logic                                           retire_valid,
  input  logic                                           retire_ready,
  output logic [((N_KERN > 1) ? $clog2(N_KERN) : 1)-1:0] retire_id,
  output logic                                           mem_req_valid,
  input  logic                                           mem_req_ready,
  output logic                                           mem_req_write,
  output logic [ADDR_W-1:0]                              mem_req_addr,
  output logic [DATA_W-1:0]                              mem_req_data,
  input  logic                                           mem_rsp_valid,
  input  logic [DATA_W-1:0]                              mem_rsp_data
);
  localparam int ID_W = (N_KERN > 1) ? $clog2(N_KERN) : 1;

  logic [WG_W-1:0]   cnt_arr    [N_KERN];
  logic [WG_W-1:0]   total_arr  [N_KERN];
  logic [ADDR_W-1:0] notify_arr [N_KERN];
  logic [ADDR_W-1:0] stamp_arr  [N_KERN];
  logic [DATA_W-1:0] ns_now;

  logic accept, hit_done, finish, seq_busy;
  logic fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [ID_W-1:0] fifo_head;
  logic err_q, wake_q, drain_q, tick_q;

  assign cmp_ready = !seq_busy;
  assign accept    = cmp_valid && cmp_ready;
  assign hit_done  = kernel_done[cmp_id];
  assign finish    = accept && !hit_done &&
                     ((cnt_arr[cmp_id] + 1'b1) == total_arr[cmp_id]);

  for (genvar k = 0; k < N_KERN; k++) begin : g_slot
    logic ld, bp;
    assign ld = launch_valid && (launch_id == ID_W'(k));
    assign bp = accept && !hit_done && (cmp_id == ID_W'(k));
    kdt_slot #(.WG_W(WG_W), .ADDR_W(ADDR_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (ld),
      .load_total  (launch_total),
      .load_notify (launch_notify_addr),
      .load_stamp  (launch_stamp_addr),
      .bump        (bp),
      .done        (kernel_done[k]),
      .count       (cnt_arr[k]),
      .total       (total_arr[k]),
      .notify      (notify_arr[k]),
      .stamp       (stamp_arr[k])
    );
  end

  kdt_ns_clock #(.TICKS_PER_NS(TICKS_PER_NS), .NS_W(DATA_W)) u_clock (
    .clk    (clk),
    .rst_n  (rst_n),
    .ns_now (ns_now)
  );

  kdt_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (finish),
    .start_notify  (notify_arr[cmp_id]),
    .start_stamp   (stamp_arr[cmp_id]),
    .start_ns      (ns_now),
    .cnt_addr      (cnt_addr),
    .busy          (seq_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  assign fifo_push = finish && !fifo_full;
  assign fifo_pop  = retire_valid && retire_ready;

  kdt_done_fifo #(.DEPTH(FIFO_DEPTH), .W(ID_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fifo_push),
    .push_data (cmp_id),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      wake_q  <= 1'b0;
      drain_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      err_q  <= accept && hit_done;
      wake_q <= sched_pass && !fifo_empty;
      if (sched_pass && !fifo_empty) drain_q <= 1'b1;
      else if (fifo_empty)           drain_q <= 1'b0;
      if (accept && !hit_done) tick_q <= 1'b1;
      else if (sched_pass)     tick_q <= 1'b0;
    end
  end

  assign cmp_err      = err_q;
  assign wake         = wake_q;
  assign tick_pending = tick_q;
  assign retire_valid = drain_q && !fifo_empty;
  assign retire_id    = fifo_head;
endmodule

// File: rtl/kernel_done_tracker_chk.sv
module kernel_done_tracker_chk #(
  parameter int N_KERN = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic              cmp_ready,
  input logic [ID_W-1:0]   cmp_id,
  input logic              cmp_err,
  input logic [N_KERN-1:0] kernel_done,
  input logic              sched_pass,
  input logic              tick_pending,
  input logic              wake,
  input logic              retire_valid,
  input logic              retire_ready,
  input logic [ID_W-1:0]   retire_id,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_data
);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data) && $stable(mem_req_write)));

  p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmp_ready);

  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(kernel_done & ~$past(kernel_done))) |-> $past(cmp_valid && cmp_ready));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_err |-> (!mem_req_valid && cmp_ready));

  p_tick_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && !kernel_done[cmp_id]) |=> tick_pending);

  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(sched_pass));

  p_retire_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !retire_ready) |=> (retire_valid && $stable(retire_id)));
endmodule

bind kernel_done_tracker kernel_done_tracker_chk #(
  .N_KERN(N_KERN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/sim_kernel_done_tracker.sv
module sim_kernel_done_tracker;
  localparam int NK = 4;
  localparam int IW = 2;
  localparam logic [31:0] CNT_A = 32'h0000_0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_valid = 1'b0;
  logic [IW-1:0] launch_id = '0;
  logic [15:0] launch_total = '0;
  logic [31:0] launch_notify_addr = '0, launch_stamp_addr = '0;
  logic cmp_valid = 1'b0;
  logic [IW-1:0] cmp_id = '0;
  logic sched_pass = 1'b0, retire_ready = 1'b0;
  logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic cmp_ready, cmp_err, tick_pending, wake, retire_valid;
  logic [NK-1:0] kernel_done;
  logic [IW-1:0] retire_id;
  logic mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_data;

  always #4 clk = ~clk;

  kernel_done_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_id(launch_id), .launch_total(launch_total),
    .launch_notify_addr(launch_notify_addr), .launch_stamp_addr(launch_stamp_addr),
    .cnt_addr(CNT_A),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_id(cmp_id), .cmp_err(cmp_err),
    .kernel_done(kernel_done), .sched_pass(sched_pass), .tick_pending(tick_pending),
    .wake(wake), .retire_valid(retire_valid), .retire_ready(retire_ready), .retire_id(retire_id),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_tests = 0, n_fail = 0;
  int bcyc = 0, wd = 0;
  bit stall = 0, rsp_pend = 0;
  logic [31:0] ctr_mem = 32'd5;
  int log_n = 0;
  logic        log_we   [16];
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];

  always @(posedge clk) begin
    if (rst_n) bcyc <= bcyc + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (log_n < 16) begin
        log_we[log_n] = mem_req_write;
        log_addr[log_n] = mem_req_addr;
        log_data[log_n] = mem_req_data;
      end
      log_n = log_n + 1;
      if (!mem_req_write) rsp_pend = 1;
      else if (mem_req_addr == CNT_A) ctr_mem = mem_req_data;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid <= rsp_pend;
    mem_rsp_data  <= ctr_mem;
    rsp_pend = 0;
    mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic launch(input int id, input int total, input logic [31:0] na, input logic [31:0] sa);
    @(negedge clk);
    launch_valid = 1; launch_id = IW'(id); launch_total = 16'(total);
    launch_notify_addr = na; launch_stamp_addr = sa;
    @(negedge clk);
    launch_valid = 0;
  endtask

  // Sends one completion; returns the bench cycle count seen before the accepting edge.
  task automatic send(input int id, output int at_cyc);
    int guard = 0;
    @(negedge clk);
    while (!cmp_ready && guard < 200) begin @(negedge clk); guard++; end
    cmp_valid = 1; cmp_id = IW'(id); at_cyc = bcyc;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!cmp_ready && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 kernel_done", kernel_done, 0);
    check("R12 tick_pending", tick_pending, 0);
    check("R12 wake", wake, 0);
    check("R12 cmp_err", cmp_err, 0);
    check("R12 retire_valid", retire_valid, 0);
    check("R12 mem_req_valid", mem_req_valid, 0);
    check("R12 cmp_ready", cmp_ready, 1);
  endtask

  task automatic t_full_sequence();
    int c;
    launch(0, 3, 32'h100, 32'h200);
    log_n = 0;
    send(0, c); send(0, c);
    check("R1 not done below total", kernel_done[0], 0);
    check("R1 no traffic below total", log_n, 0);
    send(0, c);
    check("R2 done at total", kernel_done[0], 1);
    check("R6 cmp_ready low while busy", cmp_ready, 0);
    wait_idle();
    check("R6 four requests", log_n, 4);
    check("R3 notify is write", log_we[0], 1);
    check("R3 notify addr", log_addr[0], 32'h100);
    check("R3 notify data", log_data[0], 1);
    check("R4 counter read", {log_we[1], log_addr[1]}, {1'b0, CNT_A});
    check("R4 counter write-back", {log_we[2], log_addr[2], log_data[2]}, {1'b1, CNT_A, 32'd4});
    check("R5 stamp addr", {log_we[3], log_addr[3]}, {1'b1, 32'h200});
    check("R5 stamp value", log_data[3], 32'(c / 1000));
    check("R9 tick armed", tick_pending, 1);
  endtask

  task automatic t_skip_steps();
    int c;
    launch(1, 1, 32'h0, 32'h0);
    log_n = 0;
    send(1, c);
    wait_idle();
    check("R3 R5 only two requests", log_n, 2);
    check("R3 first is counter read", {log_we[0], log_addr[0]}, {1'b0, CNT_A});
    check("R4 write-back after skip", {log_we[1], log_data[1]}, {1'b1, 32'd3});
  endtask

  task automatic t_stalled_port();
    int c;
    launch(2, 1, 32'h140, 32'h240);
    log_n = 0; stall = 1;
    send(2, c);
    wait_idle();
    stall = 0;
    check("R6 stalled count", log_n, 4);
    check("R6 stalled order", {log_addr[0], log_addr[1], log_addr[2], log_addr[3]},
          {32'h140, CNT_A, CNT_A, 32'h240});
    check("R6 stalled data", {log_data[0], log_data[2], log_data[3]},
          {32'd1, 32'd2, 32'(c / 1000)});
  endtask

  task automatic t_repeat_done();
    int c;
    log_n = 0;
    send(0, c);
    check("R10 cmp_err pulse", cmp_err, 1);
    check("R10 no request", mem_req_valid, 0);
    @(negedge clk);
    check("R10 single pulse", cmp_err, 0);
    repeat (4) @(negedge clk);
    check("R10 no traffic", log_n, 0);
    check("R10 done flags kept", kernel_done, 4'b0111);
  endtask

  task automatic t_pass_and_drain();
    check("R9 armed before pass", tick_pending, 1);
    retire_ready = 0;
    @(negedge clk); sched_pass = 1;
    @(negedge clk); sched_pass = 0;
    check("R7 wake after pass", wake, 1);
    check("R9 cleared by pass", tick_pending, 0);
    check("R8 first retire", {retire_valid, retire_id}, {1'b1, 2'd0});
    @(negedge clk);
    check("R7 one wake only", wake, 0);
    check("R8 head held", {retire_valid, retire_id}, {1'b1, 2'd0});
    retire_ready = 1;
    for (int i = 0; i < 3; i++) begin
      check("R8 retire order", {retire_valid, retire_id}, {1'b1, 2'(i)});
      @(negedge clk);
    end
    check("R8 drained", retire_valid, 0);
    @(negedge clk); sched_pass = 1;
    @(negedge clk); sched_pass = 0;
    check("R7 empty pass no wake", wake, 0);
  endtask

  task automatic t_relaunch();
    int c;
    launch(0, 2, 32'h0, 32'h0);
    check("R11 done cleared", kernel_done[0], 0);
    send(0, c);
    check("R11 count restarted", kernel_done[0], 0);
    send(0, c);
    check("R11 done again", kernel_done[0], 1);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    repeat (2100) @(negedge clk);
    t_full_sequence();
    t_skip_steps();
    repeat (1000) @(negedge clk);
    t_stalled_port();
    t_repeat_done();
    t_pass_and_drain();
    t_relaunch();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule